// File: doc/BRIEF.md
# Write-First Dual-Port RAM

This block is a single-clock memory with two fully independent access ports. Each port has its own address, write data and write enable, and each returns read data from a register one cycle after the address is presented. One clock enable, common to both ports, gates every write and every update of the read registers. When the enable is high, a port with its write enable high writes, and a port with its write enable low reads. All four combinations of the two write enables are legal.

Read results are write-first on both ports. A port that writes shows the data it just wrote on its own output in the next cycle. A port that reads the address the other port is writing in the same cycle also shows the new data. That second case is handled by comparing the two addresses and steering the other port's write data into the read register. Depth is two to the power of the address-width parameter. A second parameter chooses whether the read registers clear on a synchronous reset. The storage array itself has no reset.

Top module: `wfram_tdp`

## Requirements
- R1: While `ce` is low, no location is written, whatever the write enables are, and neither `rdata_a` nor `rdata_b` changes.
- R2: With `ce` high and a port's write enable low, that port's read output shows the contents of its addressed location from the edge after the address is presented.
- R3: With `ce` high and a port's write enable high, its write data is stored at its address on the clock edge, and later reads from either port return it.
- R4: When a port writes, its own read output shows the data just written, not the old contents, in the next cycle.
- R5: When one port reads the address that the other port writes in the same enabled cycle, the reading port's output shows the new write data in the next cycle.
- R6: Two writes in the same enabled cycle to different addresses are both stored. Each writing port's output then shows its own write data.
- R7: With `RESET_OUT` = 1, a high `rst` sampled at a clock edge clears both read outputs to zero, whatever `ce` is. Memory contents are not affected by reset.
- R8: When both ports write the same address in one cycle, each port's output shows its own write data. The stored value at that address is unspecified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset of the read registers |
| ce | input | 1 | Clock enable shared by both ports |
| we_a | input | 1 | Write enable, port A |
| we_b | input | 1 | Write enable, port B |
| addr_a | input | A_BITS | Address, port A |
| addr_b | input | A_BITS | Address, port B |
| wdata_a | input | D_BITS | Write data, port A |
| wdata_b | input | D_BITS | Write data, port B |
| rdata_a | output | D_BITS | Registered read data, port A |
| rdata_b | output | D_BITS | Registered read data, port B |

## Verification
Every result of this block, whether a plain read, an own-port write-through, a cross-port bypass or a reset clear, is due on the first rising edge after the inputs are applied. A hold under a low enable is due on that same edge. The bench changes inputs only on falling edges and samples both outputs at the next falling edge, half a period after the edge that captures them. Each step of its reference model therefore predicts exactly one registered update. The stored contents that a step leaves behind are checked in later steps by reading them back, and that includes locations targeted by writes while the enable was low.

// File: rtl/wfram_pkg.sv
package wfram_pkg;

  typedef enum logic [1:0] {
    SRC_MEM   = 2'd0,
    SRC_OWN   = 2'd1,
    SRC_OTHER = 2'd2
  } rd_src_e;

  // Own write wins, then a matching write from the other port, then the array.
  function automatic rd_src_e pick_src(input logic own_we, input logic oth_we,
                                       input logic addr_match);
    if (own_we)
      return SRC_OWN;
    else if (oth_we && addr_match)
      return SRC_OTHER;
    else
      return SRC_MEM;
  endfunction

endpackage

// File: rtl/wfram_store.sv
module wfram_store #(
  parameter int A_BITS = 6,
  parameter int D_BITS = 16,
  parameter int NPORT  = 2
) (
  input  logic                         clk,
  input  logic                         ce,
  input  logic [NPORT-1:0]             we,
  input  logic [NPORT-1:0][A_BITS-1:0] addr,
  input  logic [NPORT-1:0][D_BITS-1:0] wdata,
  output logic [NPORT-1:0][D_BITS-1:0] mem_rd
);
  localparam int DEPTH = 1 << A_BITS;

  logic [D_BITS-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ce) begin
      for (int p = 0; p < NPORT; p++) begin
        if (we[p])
          mem[addr[p]] <= wdata[p];
      end
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    assign mem_rd[p] = mem[addr[p]];
  end
endmodule

// File: rtl/wfram_rdport.sv
module wfram_rdport
  import wfram_pkg::*;
#(
  parameter int A_BITS    = 6,
  parameter int D_BITS    = 16,
  parameter bit RESET_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              own_we,
  input  logic [A_BITS-1:0] own_addr,
  input  logic [D_BITS-1:0] own_wdata,
  input  logic              oth_we,
  input  logic [A_BITS-1:0] oth_addr,
  input  logic [D_BITS-1:0] oth_wdata,
  input  logic [D_BITS-1:0] mem_rd,
  output logic [D_BITS-1:0] rdata
);
  rd_src_e           src;
  logic [D_BITS-1:0] nxt;

  always_comb begin
    src = pick_src(own_we, oth_we, own_addr == oth_addr);
    unique case (src)
      SRC_OWN:   nxt = own_wdata;
      SRC_OTHER: nxt = oth_wdata;
      default:   nxt = mem_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (RESET_OUT && rst)
      rdata <= '0;
    else if (ce)
      rdata <= nxt;
  end
endmodule

// File: rtl/wfram_tdp.sv
module wfram_tdp #(
  parameter int A_BITS    = 6,
  parameter int D_BITS    = 16,
  parameter bit RESET_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              we_a,
  input  logic              we_b,
  input  logic [A_BITS-1:0] addr_a,
  input  logic [A_BITS-1:0] addr_b,
  input  logic [D_BITS-1:0] wdata_a,
  input  logic [D_BITS-1:0] wdata_b,
  output logic [D_BITS-1:0] rdata_a,
  output logic [D_BITS-1:0] rdata_b
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]             we;
  logic [NPORT-1:0][A_BITS-1:0] addr;
  logic [NPORT-1:0][D_BITS-1:0] wdata;
  logic [NPORT-1:0][D_BITS-1:0] mem_rd;
  logic [NPORT-1:0][D_BITS-1:0] rdata;

  assign we    = {we_b, we_a};
  assign addr  = {addr_b, addr_a};
  assign wdata = {wdata_b, wdata_a};

  wfram_store #(.A_BITS(A_BITS), .D_BITS(D_BITS), .NPORT(NPORT)) u_store (
    .clk    (clk),
    .ce     (ce),
    .we     (we),
    .addr   (addr),
    .wdata  (wdata),
    .mem_rd (mem_rd)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int OTH = NPORT - 1 - p;
    wfram_rdport #(.A_BITS(A_BITS), .D_BITS(D_BITS), .RESET_OUT(RESET_OUT)) u_rd (
      .clk       (clk),
      .rst       (rst),
      .ce        (ce),
      .own_we    (we[p]),
      .own_addr  (addr[p]),
      .own_wdata (wdata[p]),
      .oth_we    (we[OTH]),
      .oth_addr  (addr[OTH]),
      .oth_wdata (wdata[OTH]),
      .mem_rd    (mem_rd[p]),
      .rdata     (rdata[p])
    );
  end

  assign rdata_a = rdata[0];
  assign rdata_b = rdata[1];
endmodule

// File: rtl/wfram_tdp_chk.sv
module wfram_tdp_chk #(
  parameter int A_BITS    = 6,
  parameter int D_BITS    = 16,
  parameter bit RESET_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              ce,
  input logic              we_a,
  input logic              we_b,
  input logic [A_BITS-1:0] addr_a,
  input logic [A_BITS-1:0] addr_b,
  input logic [D_BITS-1:0] wdata_a,
  input logic [D_BITS-1:0] wdata_b,
  input logic [D_BITS-1:0] rdata_a,
  input logic [D_BITS-1:0] rdata_b
);
  // R1: outputs hold while disabled
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(rdata_a) && $stable(rdata_b)));

  // R4 / R8: own write appears on own output
  a_r4_own_a: assert property (@(posedge clk) disable iff (rst)
    (ce && we_a) |=> (rdata_a == $past(wdata_a)));
  a_r4_own_b: assert property (@(posedge clk) disable iff (rst)
    (ce && we_b) |=> (rdata_b == $past(wdata_b)));

  // R5: cross-port bypass
  a_r5_mix_a: assert property (@(posedge clk) disable iff (rst)
    (ce && !we_a && we_b && addr_a == addr_b) |=> (rdata_a == $past(wdata_b)));
  a_r5_mix_b: assert property (@(posedge clk) disable iff (rst)
    (ce && !we_b && we_a && addr_a == addr_b) |=> (rdata_b == $past(wdata_a)));

  // R7: reset clears the read registers
  a_r7_reset: assert property (@(posedge clk)
    (RESET_OUT && rst) |=> (rdata_a == '0 && rdata_b == '0));
endmodule

bind wfram_tdp wfram_tdp_chk #(.A_BITS(A_BITS), .D_BITS(D_BITS), .RESET_OUT(RESET_OUT)) u_chk (.*);

// File: tb/sim_wfram_tdp.sv
`timescale 1ns/1ps
module sim_wfram_tdp;
  localparam int A_BITS = 6;
  localparam int D_BITS = 16;
  localparam int DEPTH  = 1 << A_BITS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0, we_a = 1'b0, we_b = 1'b0;
  logic [A_BITS-1:0] addr_a = '0, addr_b = '0;
  logic [D_BITS-1:0] wdata_a = '0, wdata_b = '0;
  logic [D_BITS-1:0] rdata_a, rdata_b;

  logic [D_BITS-1:0] ref_mem [DEPTH];
  logic [D_BITS-1:0] exp_a = '0, exp_b = '0;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wfram_tdp #(.A_BITS(A_BITS), .D_BITS(D_BITS), .RESET_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .ce(ce), .we_a(we_a), .we_b(we_b),
    .addr_a(addr_a), .addr_b(addr_b), .wdata_a(wdata_a), .wdata_b(wdata_b),
    .rdata_a(rdata_a), .rdata_b(rdata_b)
  );

  function automatic string tag_for(input logic c, input logic wa, input logic wb,
                                    input logic [A_BITS-1:0] aa,
                                    input logic [A_BITS-1:0] ab);
    if (!c) return "R1";
    if (wa && wb) return (aa == ab) ? "R8" : "R6";
    if (wa || wb) return (aa == ab) ? "R5" : "R4";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [D_BITS-1:0] got_a,
                       input logic [D_BITS-1:0] got_b);
    checks++;
    if (got_a !== exp_a || got_b !== exp_b) begin
      failures++;
      $display("FAIL %s: rdata_a=%h rdata_b=%h expected %h %h", tag, got_a, got_b,
               exp_a, exp_b);
    end
  endtask

  // One cycle: drive at negedge, capture at posedge, check at next negedge.
  task automatic step(input logic c, input logic wa, input logic wb,
                      input logic [A_BITS-1:0] aa, input logic [A_BITS-1:0] ab,
                      input logic [D_BITS-1:0] da, input logic [D_BITS-1:0] db,
                      input string tag);
    ce = c; we_a = wa; we_b = wb; addr_a = aa; addr_b = ab;
    wdata_a = da; wdata_b = db;
    if (c) begin
      exp_a = wa ? da : ((wb && aa == ab) ? db : ref_mem[aa]);
      exp_b = wb ? db : ((wa && aa == ab) ? da : ref_mem[ab]);
      if (wa) ref_mem[aa] = da;
      if (wb) ref_mem[ab] = db;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, rdata_a, rdata_b);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R7", rdata_a, rdata_b);     // cleared by reset
    rst = 1'b0;

    // R3: fill through port A, read back through port B
    for (int i = 0; i < DEPTH; i++)
      step(1, 1, 0, A_BITS'(i), '0, D_BITS'(i * 97 + 5), '0, "R3");
    for (int i = 0; i < DEPTH; i++)
      step(1, 0, 0, A_BITS'(i), A_BITS'(DEPTH - 1 - i), '0, '0, "R3");

    // R4: back-to-back writes and reads on one address
    step(1, 1, 0, 6'd7, 6'd9, 16'hAAAA, '0, "R4");
    step(1, 1, 0, 6'd7, 6'd9, 16'h5555, '0, "R4");
    step(1, 0, 0, 6'd7, 6'd7, '0, '0, "R2");
    // R5: port A reads what port B writes, then the reverse
    step(1, 0, 1, 6'd12, 6'd12, 16'h1111, 16'hBEEF, "R5");
    step(1, 1, 0, 6'd13, 6'd13, 16'hCAFE, 16'h2222, "R5");
    step(1, 0, 0, 6'd12, 6'd13, '0, '0, "R3");
    // R6: two writes to different addresses
    step(1, 1, 1, 6'd20, 6'd21, 16'h0F0F, 16'hF0F0, "R6");
    step(1, 0, 0, 6'd21, 6'd20, '0, '0, "R6");
    // R1: disabled writes change nothing
    step(0, 1, 1, 6'd20, 6'd21, 16'hDEAD, 16'hDEAD, "R1");
    step(1, 0, 0, 6'd20, 6'd21, '0, '0, "R1");
    // R8: both write one address; outputs only, then restore the location
    step(1, 1, 1, 6'd30, 6'd30, 16'h1234, 16'h4321, "R8");
    step(1, 1, 0, 6'd30, 6'd31, 16'h7777, '0, "R8");
    // R7: reset during activity clears outputs, memory kept
    rst = 1'b1; ce = 1'b0; we_a = 1'b0; we_b = 1'b0;
    exp_a = '0; exp_b = '0;
    @(posedge clk); @(negedge clk);
    check("R7", rdata_a, rdata_b);
    rst = 1'b0;
    step(1, 0, 0, 6'd30, 6'd12, '0, '0, "R7");

    // Random mix, addresses often narrowed to provoke collisions
    for (int n = 0; n < 3000; n++) begin
      logic c, wa, wb;
      logic [A_BITS-1:0] aa, ab;
      logic [D_BITS-1:0] da, db;
      bit narrow;
      narrow = ($urandom % 2) == 0;
      c  = ($urandom % 8) != 0;
      wa = $urandom % 2;
      wb = $urandom % 2;
      aa = narrow ? A_BITS'($urandom % 4) : A_BITS'($urandom);
      ab = narrow ? A_BITS'($urandom % 4) : A_BITS'($urandom);
      if (wa && wb && aa == ab) ab = aa + 1'b1;
      da = D_BITS'($urandom);
      db = D_BITS'($urandom);
      step(c, wa, wb, aa, ab, da, db, tag_for(c, wa, wb, aa, ab));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule